// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC and decides what happens once the medium reports a collision. While a transmit attempt is in progress it counts the bit times already put on the wire, preamble included. When a collision is seen it takes over the data line and sends a run of all-ones jam bits. If the collision came while preamble was still going out, the preamble is allowed to finish and the jam follows it.

Once the jam has ended, the block picks one of three outcomes. A collision inside the first 512 bit times leads to a retry. The block then waits a pseudo-random whole number of slot times and signals when the wait is over. A collision after that window abandons the frame with a late-collision indication. Reaching the attempt limit abandons the frame with an excessive-retry indication.

The surrounding transmitter drives a one-cycle `new_frame` strobe when it starts a fresh frame. This strobe clears the attempt history. All timing advances on a bit-time enable, so the block works with any ratio of system clock to line rate.

Top module: `eth_coll_backoff`

## Requirements
- R1: After a collision, `jam_en` is high for exactly `JAM_BITS` (default 32) bit-enable pulses, and `jam_data` is 1 throughout. For a collision outside preamble, the first jam bit is the next bit after the collision cycle.
- R2: When `col_det` is seen while `in_preamble` is high, no jam bit is sent while `in_preamble` stays high. The first jam bit is the first bit sent after `in_preamble` falls.
- R3: Suppose the bit count of the attempt is below `LATE_BITS` (default 512) when the collision is detected. Then at the end of the jam `retry_req` pulses for one cycle, unless the attempt limit has been reached. The bit count covers bits sent since `tx_active` started the attempt, preamble included.
- R4: Suppose the bit count is `LATE_BITS` or more when the collision is detected. Then `retry_req` does not pulse. Instead `abort_late` pulses at the end of the jam, and `late_col` goes high and stays high.
- R5: After `retry_req` for the n-th collision of a frame, the wait is k × `SLOT_BITS` bit-enable pulses. Here k is a whole number from 0 to 2^min(n,`BK_CAP`) − 1, with `BK_CAP` defaulting to 10 and `SLOT_BITS` to 512. k is taken from a free-running LFSR.
- R6: At the end of the wait, `backoff_done` is high for exactly one cycle, and the block is then idle and ready to start the next attempt on `tx_active`.
- R7: The `RETRY_LIMIT`-th collision of a frame (default 16) ends with an `abort_excess` pulse in place of `retry_req`.
- R8: A `new_frame` pulse clears the attempt count and `late_col`. The next early collision then retries, whatever the attempt history.
- R9: Out of reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One pulse per line bit time |
| tx_active | input | 1 | Transmitter is sending the current attempt |
| in_preamble | input | 1 | Bits now going out are preamble |
| col_det | input | 1 | Collision reported by the medium |
| new_frame | input | 1 | One-cycle strobe: a fresh frame begins |
| jam_en | output | 1 | Jam owns the transmit data line |
| jam_data | output | 1 | Jam bit value (all ones) |
| retry_req | output | 1 | One-cycle pulse: retry scheduled, backoff begins |
| backoff_done | output | 1 | One-cycle pulse: backoff wait finished |
| abort_late | output | 1 | One-cycle pulse: frame dropped for late collision |
| abort_excess | output | 1 | One-cycle pulse: frame dropped at attempt limit |
| late_col | output | 1 | Sticky late-collision status until next frame |

## Verification
The bench places collisions at bit 511 and bit 512 of an attempt. A window compare off by one would retry the frame at 512 or abandon it at 511. A collision halfway through preamble must give a jam that starts on the first bit after the preamble. A design that jams at once would overwrite preamble, and one that loses the deferred collision would never jam at all. Each backoff wait is measured in bit times and must be a whole number of slots below the cap for that attempt. A mask built from the wrong attempt number, or a slot timer off by one, shows up as an illegal wait. Sixteen back-to-back early collisions must end in an excessive-retry abort, and a following `new_frame` must bring back an ordinary retry. A counter that does not clear would abort again at once.

// File: rtl/eth_cb_pkg.sv
package eth_cb_pkg;

   typedef enum logic [2:0] {
      CB_IDLE,
      CB_SEND,
      CB_HOLD,
      CB_JAM,
      CB_WAIT
   } cb_state_e;

endpackage

// File: rtl/eth_cb_lfsr.sv
module eth_cb_lfsr #(
   parameter int                  LFSR_W = 16,
   parameter int                  OUT_W  = 10,
   parameter logic [LFSR_W-1:0]   SEED   = LFSR_W'(1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);

   logic [LFSR_W-1:0] taps;
   logic [LFSR_W-1:0] state_q;

   generate
      if (LFSR_W == 16) begin : g_w16
         assign taps = LFSR_W'(32'h0000_B400);
      end else if (LFSR_W == 24) begin : g_w24
         assign taps = LFSR_W'(32'h00E1_0000);
      end else if (LFSR_W == 32) begin : g_w32
         assign taps = LFSR_W'(32'h8020_0003);
      end else begin : g_bad_w
         $error("eth_cb_lfsr: LFSR_W must be 16, 24 or 32");
      end
      if (OUT_W > LFSR_W) begin : g_bad_out
         $error("eth_cb_lfsr: OUT_W exceeds LFSR_W");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("eth_cb_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= SEED;
      else if (state_q[0])
         state_q <= (state_q >> 1) ^ taps;
      else
         state_q <= state_q >> 1;
   end

   assign rnd = state_q[OUT_W-1:0];

endmodule

// File: rtl/eth_cb_window.sv
module eth_cb_window #(
   parameter int LATE_BITS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic late
);

   localparam int CNT_W = $clog2(LATE_BITS + 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (LATE_BITS < 1) begin : g_bad_late
         $error("eth_cb_window: LATE_BITS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (count_en && (cnt_q != CNT_W'(LATE_BITS)))
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign late = (cnt_q == CNT_W'(LATE_BITS));

endmodule

// File: rtl/eth_cb_slot_timer.sv
module eth_cb_slot_timer #(
   parameter int SLOT_BITS = 512,
   parameter int CAP_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CAP_W-1:0] slots,
   input  logic             run,
   input  logic             bit_en,
   output logic             expired
);

   localparam int SUB_W = $clog2(SLOT_BITS);

   logic [CAP_W-1:0] slots_q;
   logic [SUB_W-1:0] sub_q;

   generate
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("eth_cb_slot_timer: SLOT_BITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q <= '0;
         sub_q   <= '0;
      end else if (load) begin
         slots_q <= slots;
         sub_q   <= '0;
      end else if (run && bit_en && (slots_q != '0)) begin
         if (sub_q == SUB_W'(SLOT_BITS - 1)) begin
            sub_q   <= '0;
            slots_q <= slots_q - CAP_W'(1);
         end else begin
            sub_q <= sub_q + SUB_W'(1);
         end
      end
   end

   assign expired = (slots_q == '0);

endmodule

// File: rtl/eth_coll_backoff.sv
module eth_coll_backoff
   import eth_cb_pkg::*;
#(
   parameter int                 JAM_BITS    = 32,
   parameter int                 LATE_BITS   = 512,
   parameter int                 SLOT_BITS   = 512,
   parameter int                 BK_CAP      = 10,
   parameter int                 RETRY_LIMIT = 16,
   parameter int                 LFSR_W      = 16,
   parameter logic [LFSR_W-1:0]  LFSR_SEED   = LFSR_W'(16'hACE1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic tx_active,
   input  logic in_preamble,
   input  logic col_det,
   input  logic new_frame,
   output logic jam_en,
   output logic jam_data,
   output logic retry_req,
   output logic backoff_done,
   output logic abort_late,
   output logic abort_excess,
   output logic late_col
);

   localparam int JAM_W = $clog2(JAM_BITS + 1);
   localparam int ATT_W = $clog2(RETRY_LIMIT + 1);

   generate
      if (JAM_BITS < 2) begin : g_bad_jam
         $error("eth_coll_backoff: JAM_BITS must be at least 2");
      end
      if (RETRY_LIMIT < 1) begin : g_bad_limit
         $error("eth_coll_backoff: RETRY_LIMIT must be at least 1");
      end
      if (BK_CAP < 1 || BK_CAP > LFSR_W) begin : g_bad_cap
         $error("eth_coll_backoff: BK_CAP must lie in 1..LFSR_W");
      end
   endgenerate

   cb_state_e         st_q;
   logic [JAM_W-1:0]  jam_cnt_q;
   logic [ATT_W-1:0]  att_q;
   logic              late_hit_q;
   logic              win_late;
   logic              bo_expired;
   logic [BK_CAP-1:0] rnd;
   logic [BK_CAP-1:0] mask;
   logic              jam_last;
   logic              at_limit;
   logic              bo_load;

   eth_cb_lfsr #(
      .LFSR_W (LFSR_W),
      .OUT_W  (BK_CAP),
      .SEED   (LFSR_SEED)
   ) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   eth_cb_window #(
      .LATE_BITS (LATE_BITS)
   ) window_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (st_q == CB_IDLE),
      .count_en ((st_q == CB_SEND) && bit_en),
      .late     (win_late)
   );

   eth_cb_slot_timer #(
      .SLOT_BITS (SLOT_BITS),
      .CAP_W     (BK_CAP)
   ) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (bo_load),
      .slots   (rnd & mask),
      .run     (st_q == CB_WAIT),
      .bit_en  (bit_en),
      .expired (bo_expired)
   );

   // Backoff range mask: low min(n, BK_CAP) bits set, n = this collision's number
   always_comb begin
      for (int i = 0; i < BK_CAP; i++)
         mask[i] = (i < int'(att_q) + 1);
   end

   assign jam_en   = (st_q == CB_JAM) || ((st_q == CB_HOLD) && !in_preamble);
   assign jam_data = jam_en;
   assign jam_last = jam_en && bit_en && (jam_cnt_q == JAM_W'(JAM_BITS - 1));
   assign at_limit = (att_q == ATT_W'(RETRY_LIMIT - 1));
   assign bo_load  = jam_last && !late_hit_q && !at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= CB_IDLE;
         jam_cnt_q    <= '0;
         att_q        <= '0;
         late_hit_q   <= 1'b0;
         late_col     <= 1'b0;
         retry_req    <= 1'b0;
         backoff_done <= 1'b0;
         abort_late   <= 1'b0;
         abort_excess <= 1'b0;
      end else begin
         retry_req    <= 1'b0;
         backoff_done <= 1'b0;
         abort_late   <= 1'b0;
         abort_excess <= 1'b0;
         if (new_frame) begin
            att_q    <= '0;
            late_col <= 1'b0;
         end
         unique case (st_q)
            CB_IDLE: begin
               if (tx_active) st_q <= CB_SEND;
            end
            CB_SEND: begin
               if (!tx_active) begin
                  st_q <= CB_IDLE;
               end else if (col_det) begin
                  late_hit_q <= win_late;
                  jam_cnt_q  <= '0;
                  st_q       <= in_preamble ? CB_HOLD : CB_JAM;
               end
            end
            CB_HOLD, CB_JAM: begin
               if (jam_last) begin
                  if (late_hit_q) begin
                     abort_late <= 1'b1;
                     late_col   <= 1'b1;
                     st_q       <= CB_IDLE;
                  end else if (at_limit) begin
                     abort_excess <= 1'b1;
                     st_q         <= CB_IDLE;
                  end else begin
                     att_q     <= att_q + ATT_W'(1);
                     retry_req <= 1'b1;
                     st_q      <= CB_WAIT;
                  end
               end else begin
                  if (jam_en && bit_en) jam_cnt_q <= jam_cnt_q + JAM_W'(1);
                  if (jam_en) st_q <= CB_JAM;
               end
            end
            CB_WAIT: begin
               if (bo_expired) begin
                  backoff_done <= 1'b1;
                  st_q         <= CB_IDLE;
               end
            end
            default: st_q <= CB_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eth_cb_chk.sv
module eth_cb_chk #(
   parameter int JAM_BITS = 32
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic in_preamble,
   input logic new_frame,
   input logic jam_en,
   input logic jam_data,
   input logic retry_req,
   input logic backoff_done,
   input logic abort_late,
   input logic abort_excess,
   input logic late_col
);

   int unsigned jam_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         jam_seen_q <= 0;
      else if (!jam_en)
         jam_seen_q <= 0;
      else if (bit_en)
         jam_seen_q <= jam_seen_q + 1;
   end

   // R1
   jam_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jam_en) |-> (jam_seen_q == JAM_BITS));

   // R1
   jam_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jam_en |-> jam_data);

   // R2
   jam_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jam_en |-> !in_preamble);

   // R3
   retry_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> $past(jam_en));

   // R4
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retry_req, abort_late, abort_excess, backoff_done}));

   // R4
   late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_late |-> late_col);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backoff_done |=> !backoff_done);

   // R8
   new_frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_frame |=> (!late_col || abort_late));

endmodule

bind eth_coll_backoff eth_cb_chk #(.JAM_BITS(JAM_BITS)) chk_i (.*);

// File: tb/eth_coll_backoff_tb_top.sv
`timescale 1ns/1ps
module eth_coll_backoff_tb_top;

   localparam int SLOT = 8;
   localparam int JAM  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic tx_active = 1'b0;
   logic in_preamble = 1'b0;
   logic col_det = 1'b0;
   logic new_frame = 1'b0;
   logic jam_en, jam_data, retry_req, backoff_done;
   logic abort_late, abort_excess, late_col;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   eth_coll_backoff #(.SLOT_BITS(SLOT)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_en       (bit_en),
      .tx_active    (tx_active),
      .in_preamble  (in_preamble),
      .col_det      (col_det),
      .new_frame    (new_frame),
      .jam_en       (jam_en),
      .jam_data     (jam_data),
      .retry_req    (retry_req),
      .backoff_done (backoff_done),
      .abort_late   (abort_late),
      .abort_excess (abort_excess),
      .late_col     (late_col)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_new_frame();
      @(negedge clk);
      new_frame = 1'b1;
      @(negedge clk);
      new_frame = 1'b0;
   endtask

   // res: 1 retry, 2 late abort, 3 excess abort, 0 nothing
   task automatic run_attempt(input int pre_bits, input int coll_bit,
                              output int jbits, output int jbad,
                              output int jstart, output int res);
      int  sent;
      bit  collided;
      sent = 0; jbits = 0; jbad = 0; jstart = -1; res = 0; collided = 1'b0;
      @(negedge clk);
      tx_active = 1'b1; in_preamble = (pre_bits > 0); bit_en = 1'b0; col_det = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (retry_req) res = 1;
         else if (abort_late) res = 2;
         else if (abort_excess) res = 3;
         if (res != 0) break;
         in_preamble = (sent < pre_bits);
         if (!collided && sent == coll_bit) begin
            col_det = 1'b1; bit_en = 1'b0; collided = 1'b1;
         end else begin
            col_det = 1'b0; bit_en = 1'b1;
         end
         #1;
         if (bit_en) begin
            if (jam_en) begin
               if (jstart < 0) jstart = sent;
               jbits++;
               if (!jam_data) jbad++;
            end
            sent++;
         end
      end
      tx_active = 1'b0; col_det = 1'b0; in_preamble = 1'b0;
      bit_en = (res == 1);
   endtask

   task automatic check_backoff(input int n);
      int cnt;
      int k;
      int cap;
      cnt = 1;
      for (int g = 0; g < 20000; g++) begin
         @(negedge clk);
         if (backoff_done) break;
         bit_en = 1'b1;
         cnt++;
      end
      bit_en = 1'b0;
      chk(backoff_done, "R6 backoff_done seen", int'(backoff_done), 1);
      k   = (cnt - 1) / SLOT;
      cap = (1 << ((n < 10) ? n : 10)) - 1;
      chk(((cnt - 1) % SLOT) == 0, "R5 wait whole slots", cnt - 1, k * SLOT);
      chk(k <= cap, "R5 slot count in range", k, cap);
      @(negedge clk);
      chk(!backoff_done, "R6 backoff_done one cycle", int'(backoff_done), 0);
   endtask

   task automatic t_reset();
      #1;
      chk({jam_en, jam_data, retry_req, backoff_done, abort_late, abort_excess, late_col} == 7'b0,
          "R9 outputs low in reset", 1, 0);
   endtask

   task automatic t_early();
      int jb, bad, js, res;
      pulse_new_frame();
      run_attempt(64, 200, jb, bad, js, res);
      chk(jb == JAM, "R1 jam length early", jb, JAM);
      chk(bad == 0, "R1 jam all ones", bad, 0);
      chk(js == 200, "R1 jam start after collision", js, 200);
      chk(res == 1, "R3 early collision retries", res, 1);
      if (res == 1) check_backoff(1);
   endtask

   task automatic t_preamble();
      int jb, bad, js, res;
      pulse_new_frame();
      run_attempt(64, 20, jb, bad, js, res);
      chk(js == 64, "R2 jam starts after preamble", js, 64);
      chk(jb == JAM, "R1 jam length after preamble", jb, JAM);
      chk(res == 1, "R3 preamble collision retries", res, 1);
      if (res == 1) check_backoff(1);
   endtask

   task automatic t_boundary();
      int jb, bad, js, res;
      pulse_new_frame();
      run_attempt(64, 511, jb, bad, js, res);
      chk(res == 1, "R3 collision at bit 511 retries", res, 1);
      chk(!late_col, "R3 no late flag at bit 511", int'(late_col), 0);
      if (res == 1) check_backoff(1);
      pulse_new_frame();
      run_attempt(64, 512, jb, bad, js, res);
      chk(res == 2, "R4 collision at bit 512 aborts late", res, 2);
      chk(jb == JAM, "R4 late collision still jams", jb, JAM);
      repeat (20) @(negedge clk);
      chk(late_col, "R4 late_col held", int'(late_col), 1);
      chk(!retry_req && !backoff_done, "R4 no retry after late", int'(retry_req), 0);
      pulse_new_frame();
      #1;
      chk(!late_col, "R8 new_frame clears late_col", int'(late_col), 0);
   endtask

   task automatic t_excess();
      int jb, bad, js, res;
      pulse_new_frame();
      for (int a = 1; a <= 16; a++) begin
         run_attempt(0, 10, jb, bad, js, res);
         if (a < 16) begin
            chk(res == 1, "R5 retry before limit", res, 1);
            if (res == 1) check_backoff(a);
         end else begin
            chk(res == 3, "R7 limit gives abort_excess", res, 3);
         end
      end
      pulse_new_frame();
      run_attempt(0, 10, jb, bad, js, res);
      chk(res == 1, "R8 new_frame resets attempts", res, 1);
      if (res == 1) check_backoff(1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_early();
      t_preamble();
      t_boundary();
      t_excess();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule